// File: doc/BRIEF.md
# Dynamic Bus Sizing Transfer Sequencer

This block takes one processor-side access (a byte address, an operand length of one, two or four bytes, a direction and, for writes, the operand) and turns it into a run of cycles on an external 32-bit bus. The device answering each cycle may narrow the bus for that one cycle to 16 or 8 bits. The block then breaks the current piece of the operand into more cycles. Reads are gathered back into an operand that is returned with a one-clock done pulse.

The order of the cycles is fixed. An operand that straddles a dword boundary is moved in two pieces. The piece in the higher dword goes first and the piece in the lower dword follows. Inside a piece, any extra cycles forced by a narrow answer move the bytes lowest address first. The width is sampled again on every ready, so one operand may see several widths.

The request side is a valid/ready handshake. The requester holds `req_valid` and every request field steady until `req_ready` is seen high at a clock edge, and that edge accepts the request. `req_ready` stays low for the whole sequence, so there is only ever one access in flight. The result side has no back-pressure: `done_valid` is high for exactly one clock, and the requester must take `done_rdata` in that clock. The bus pins are plain control signals.

Top module: `dyn_bus_sizer`

## Requirements
- R1: While reset is held and just after it is released: `req_ready`=1, `bus_cyc`=0, `done_valid`=0, `bus_ben_n`=4'b1111.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_len` codes: 00 = 1 byte, 01 = 2 bytes, 10 = 4 bytes, 11 = 4 bytes. `req_ready` stays 0 from acceptance until the final bus cycle completes. Requests offered in that time are not taken and leave the bus sequence unchanged.
- R3: Byte lane i of the bus (data bits 8i+7:8i) carries the byte whose address has low bits i. `bus_ben_n[i]` is an active-low enable for lane i. An operand that lies in one dword is one piece at dword address `req_addr[AW-1:2]`, with only its own lanes enabled.
- R4: An operand that crosses a dword boundary is split into two pieces. The first piece is at the next dword, on the lanes of its upper-addressed bytes. The second piece is at the request's dword, on the remaining lanes. For example, a 4-byte operand at low bits 11 enables lanes 0-2 first and then lane 3.
- R5: `bus_sz16`=1 (with `bus_sz8`=0) at a `bus_rdy` edge narrows that cycle. If lanes 0 or 1 are still pending, only those lanes move. Otherwise lanes 2-3 move. The bytes still pending stay enabled for the next cycle at the same dword.
- R6: `bus_sz8`=1 at a `bus_rdy` edge moves only the lowest pending lane. `bus_sz8` wins over `bus_sz16`. With neither asserted, all enabled lanes move in that cycle.
- R7: The width is sampled again on every `bus_rdy`. Across any mix of widths, every operand byte is moved exactly once. The order is the first piece in ascending address, then the second piece in ascending address.
- R8: Write data sits on its natural lane. Lane 0 also carries the lowest pending byte. When lanes 0 and 1 are both idle, lane 1 also carries the lane 3 byte. A 16-bit device therefore reads from bits 15:0 and an 8-bit device from bits 7:0.
- R9: Read data for a moved lane i is taken from `bus_rdata` bits 8i+7:8i at full width, bits 8(i mod 2)+7:8(i mod 2) at 16 bits, and bits 7:0 at 8 bits. `done_rdata` byte k holds the byte at `req_addr`+k. Bytes beyond the operand length are 0.
- R10: `done_valid` is 1 for exactly one clock, in the clock after the `bus_rdy` edge that moves the last byte. `bus_cyc` is 0 and `req_ready` is 1 from that same clock on.
- R11: While `bus_cyc`=1 and `bus_rdy`=0, `bus_addr`, `bus_ben_n` and `bus_wdata` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Access request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | AW | Byte address of the operand |
| req_len | input | 2 | Operand length code |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write operand, byte k for address+k |
| done_valid | output | 1 | One-clock completion pulse |
| done_rdata | output | 32 | Assembled read operand |
| bus_cyc | output | 1 | A bus cycle is outstanding |
| bus_addr | output | AW-2 | Dword address of the cycle |
| bus_ben_n | output | 4 | Active-low byte enables |
| bus_we | output | 1 | Cycle direction, 1 = write |
| bus_wdata | output | 32 | Steered write data |
| bus_rdata | input | 32 | Read data from the device |
| bus_rdy | input | 1 | Ends the current cycle |
| bus_sz16 | input | 1 | Device answers 16 bits wide |
| bus_sz8 | input | 1 | Device answers 8 bits wide |

## Verification
Directed accesses are run under responders fixed at 32, 16 and 8 bits, and under a responder that raises both size inputs. The cycle counts and first-cycle enables they give separate the piece order, the low-half-first rule, one byte per cycle, and the priority of the 8-bit input. Randomised address, length and direction are then run against a responder that picks a new width and wait on every cycle. There the scoreboard checks each moved byte address and data lane against a fixed order. That order must not depend on width, so it exposes any byte that is repeated, skipped or reordered when widths change in the middle of an operand. A spurious request held during a busy sequence shows that requests are ignored while one is in flight.

// File: rtl/bsz_pkg.sv
package bsz_pkg;
  localparam int LANES  = 4;
  localparam int DATA_W = 8 * LANES;

  typedef logic [LANES-1:0] lane_mask_t;

  typedef enum logic [1:0] {
    BW32 = 2'd0,
    BW16 = 2'd1,
    BW8  = 2'd2
  } bus_width_e;

  // operand byte k moves to lane (k + off) mod 4
  function automatic logic [DATA_W-1:0] lanes_from_operand(
      input logic [DATA_W-1:0] d, input logic [1:0] off);
    logic [DATA_W-1:0] r;
    r = '0;
    for (int k = 0; k < LANES; k++) begin
      r[8*((k + int'(off)) % LANES) +: 8] = d[8*k +: 8];
    end
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] operand_from_lanes(
      input logic [DATA_W-1:0] d, input logic [1:0] off);
    logic [DATA_W-1:0] r;
    r = '0;
    for (int k = 0; k < LANES; k++) begin
      r[8*k +: 8] = d[8*((k + int'(off)) % LANES) +: 8];
    end
    return r;
  endfunction
endpackage

// File: rtl/bsz_plan.sv
module bsz_plan
  import bsz_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr,
  input  logic [1:0]    len,
  output logic [AW-3:0] first_dw,
  output lane_mask_t    first_mask,
  output logic [AW-3:0] second_dw,
  output lane_mask_t    second_mask,
  output logic          has_second
);
  localparam int DWW = AW - 2;

  logic [DWW-1:0] base_dw;
  logic [3:0]     len_mask;
  logic [7:0]     span;

  assign base_dw = addr[AW-1:2];

  always_comb begin
    unique case (len)
      2'b00:   len_mask = 4'b0001;
      2'b01:   len_mask = 4'b0011;
      default: len_mask = 4'b1111;
    endcase
    span = {4'b0000, len_mask} << addr[1:0];
  end

  always_comb begin
    has_second = |span[7:4];
    if (has_second) begin
      first_dw    = base_dw + DWW'(1);
      first_mask  = span[7:4];
      second_dw   = base_dw;
      second_mask = span[3:0];
    end else begin
      first_dw    = base_dw;
      first_mask  = span[3:0];
      second_dw   = base_dw;
      second_mask = '0;
    end
  end
endmodule

// File: rtl/bsz_split.sv
module bsz_split
  import bsz_pkg::*;
(
  input  lane_mask_t pending,
  input  bus_width_e width,
  output lane_mask_t moved,
  output lane_mask_t left
);
  lane_mask_t lowest;

  assign lowest = pending & (~pending + lane_mask_t'(1));

  always_comb begin
    unique case (width)
      BW8:  moved = lowest;
      BW16: moved = (|pending[1:0]) ? (pending & 4'b0011) : (pending & 4'b1100);
      default: moved = pending;
    endcase
    left = pending & ~moved;
  end
endmodule

// File: rtl/bsz_wsteer.sv
module bsz_wsteer
  import bsz_pkg::*;
(
  input  logic [DATA_W-1:0] lane_data,
  input  lane_mask_t        pending,
  output logic [DATA_W-1:0] bus_data
);
  logic [7:0] low_byte;

  always_comb begin
    low_byte = lane_data[7:0];
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pending[i]) low_byte = lane_data[8*i +: 8];
    end
  end

  always_comb begin
    bus_data       = lane_data;
    bus_data[7:0]  = low_byte;
    if (pending[1:0] == 2'b00) bus_data[15:8] = lane_data[31:24];
  end
endmodule

// File: rtl/bsz_rcap.sv
module bsz_rcap
  import bsz_pkg::*;
(
  input  logic [DATA_W-1:0] held,
  input  logic [DATA_W-1:0] rdata,
  input  lane_mask_t        moved,
  input  bus_width_e        width,
  output logic [DATA_W-1:0] held_next
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] src;
    always_comb begin
      unique case (width)
        BW8:     src = rdata[7:0];
        BW16:    src = rdata[8*(l % 2) +: 8];
        default: src = rdata[8*l +: 8];
      endcase
    end
    assign held_next[8*l +: 8] = moved[l] ? src : held[8*l +: 8];
  end
endmodule

// File: rtl/dyn_bus_sizer.sv
module dyn_bus_sizer
  import bsz_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_len,
  input  logic          req_write,
  input  logic [31:0]   req_wdata,
  output logic          done_valid,
  output logic [31:0]   done_rdata,
  output logic          bus_cyc,
  output logic [AW-3:0] bus_addr,
  output logic [3:0]    bus_ben_n,
  output logic          bus_we,
  output logic [31:0]   bus_wdata,
  input  logic [31:0]   bus_rdata,
  input  logic          bus_rdy,
  input  logic          bus_sz16,
  input  logic          bus_sz8
);
  localparam int DWW = AW - 2;

  // sequence state
  logic              busy;
  logic [DWW-1:0]    cur_dw;
  lane_mask_t        cur_mask;
  logic              more;
  logic [DWW-1:0]    next_dw;
  lane_mask_t        next_mask;
  logic [1:0]        off;
  logic              we;
  logic [DATA_W-1:0] wlanes;
  logic [DATA_W-1:0] rlanes;

  // plan of the incoming request
  logic [DWW-1:0] p_first_dw, p_second_dw;
  lane_mask_t     p_first_mask, p_second_mask;
  logic           p_two;

  bsz_plan #(.AW(AW)) u_plan (
    .addr        (req_addr),
    .len         (req_len),
    .first_dw    (p_first_dw),
    .first_mask  (p_first_mask),
    .second_dw   (p_second_dw),
    .second_mask (p_second_mask),
    .has_second  (p_two)
  );

  // width seen on this cycle, 8-bit request has priority
  bus_width_e width;
  always_comb begin
    if (bus_sz8)       width = BW8;
    else if (bus_sz16) width = BW16;
    else               width = BW32;
  end

  lane_mask_t moved, left;
  bsz_split u_split (
    .pending (cur_mask),
    .width   (width),
    .moved   (moved),
    .left    (left)
  );

  logic [DATA_W-1:0] rlanes_next;
  bsz_rcap u_rcap (
    .held      (rlanes),
    .rdata     (bus_rdata),
    .moved     (moved),
    .width     (width),
    .held_next (rlanes_next)
  );

  logic [DATA_W-1:0] steered;
  bsz_wsteer u_wsteer (
    .lane_data (wlanes),
    .pending   (cur_mask),
    .bus_data  (steered)
  );

  logic accept, step;
  assign accept = req_valid && !busy;
  assign step   = busy && bus_rdy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      cur_dw     <= '0;
      cur_mask   <= '0;
      more       <= 1'b0;
      next_dw    <= '0;
      next_mask  <= '0;
      off        <= '0;
      we         <= 1'b0;
      wlanes     <= '0;
      rlanes     <= '0;
      done_valid <= 1'b0;
      done_rdata <= '0;
    end else begin
      done_valid <= 1'b0;
      if (accept) begin
        busy      <= 1'b1;
        cur_dw    <= p_first_dw;
        cur_mask  <= p_first_mask;
        more      <= p_two;
        next_dw   <= p_second_dw;
        next_mask <= p_second_mask;
        off       <= req_addr[1:0];
        we        <= req_write;
        wlanes    <= lanes_from_operand(req_wdata, req_addr[1:0]);
        rlanes    <= '0;
      end else if (step) begin
        rlanes <= rlanes_next;
        if (left != '0) begin
          cur_mask <= left;
        end else if (more) begin
          cur_dw   <= next_dw;
          cur_mask <= next_mask;
          more     <= 1'b0;
        end else begin
          busy       <= 1'b0;
          cur_mask   <= '0;
          done_valid <= 1'b1;
          done_rdata <= operand_from_lanes(rlanes_next, off);
        end
      end
    end
  end

  assign req_ready = !busy;
  assign bus_cyc   = busy;
  assign bus_addr  = cur_dw;
  assign bus_ben_n = busy ? ~cur_mask : 4'b1111;
  assign bus_we    = we;
  assign bus_wdata = steered;
endmodule

// File: rtl/dyn_bus_sizer_chk.sv
module dyn_bus_sizer_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          done_valid,
  input logic          bus_cyc,
  input logic [AW-3:0] bus_addr,
  input logic [3:0]    bus_ben_n,
  input logic [31:0]   bus_wdata,
  input logic          bus_rdy,
  input logic          bus_sz8
);
  // R2
  busy_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc |-> !req_ready);

  // R3
  some_lane_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc |-> (bus_ben_n != 4'b1111));

  // R6
  one_byte_per_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && bus_rdy && bus_sz8 && ($countones(~bus_ben_n) > 1)) |=>
      (bus_cyc && ($countones(~bus_ben_n) == $past($countones(~bus_ben_n)) - 1)));

  // R10
  done_after_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> ($past(bus_rdy) && $past(bus_cyc) && !bus_cyc));

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid);

  // R11
  hold_on_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc && !bus_rdy) |=>
      (bus_cyc && $stable(bus_ben_n) && $stable(bus_addr) && $stable(bus_wdata)));
endmodule

bind dyn_bus_sizer dyn_bus_sizer_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .done_valid (done_valid),
  .bus_cyc    (bus_cyc),
  .bus_addr   (bus_addr),
  .bus_ben_n  (bus_ben_n),
  .bus_wdata  (bus_wdata),
  .bus_rdy    (bus_rdy),
  .bus_sz8    (bus_sz8)
);

// File: tb/dyn_bus_sizer_tb.sv
module dyn_bus_sizer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_len = '0;
  logic        done_valid;
  logic [31:0] done_rdata;
  logic        bus_cyc, bus_we;
  logic [29:0] bus_addr;
  logic [3:0]  bus_ben_n;
  logic [31:0] bus_wdata, bus_rdata = '0;
  logic        bus_rdy = 1'b0, bus_sz16 = 1'b0, bus_sz8 = 1'b0;

  always #5 clk = ~clk;

  dyn_bus_sizer u_dut (.*);

  int errors = 0, checks = 0;
  logic [31:0] exp_a[$];
  logic [7:0]  exp_d[$];
  logic [31:0] exp_res[$];
  logic        exp_rd[$];
  int          mode = 1;     // 0 random, 1 w32, 2 w16, 3 w8, 4 both size inputs
  int          cyc_cnt, dones = 0;
  logic        first_seen;
  logic [3:0]  first_ben;
  logic [29:0] first_dw;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    logic [7:0] t;
    t = a[7:0] * 8'd29;
    return t ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic int count_cycles(input logic [3:0] m, input int w);
    if (m == 4'b0000) return 0;
    if (w == 32) return 1;
    if (w == 16) return int'(|m[1:0]) + int'(|m[3:2]);
    return $countones(m);
  endfunction

  // responder and scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      bus_rdy = 1'b0; bus_sz16 = 1'b0; bus_sz8 = 1'b0;
      if (bus_cyc) begin
        if (!first_seen) begin
          first_seen = 1'b1; first_ben = bus_ben_n; first_dw = bus_addr;
        end
        if (($urandom % 4) != 0) begin
          int w;
          logic [3:0] m, mv;
          case (mode)
            1: w = 32;
            2: w = 16;
            3, 4: w = 8;
            default: begin
              int r;
              r = int'($urandom % 3);
              w = (r == 0) ? 32 : (r == 1) ? 16 : 8;
            end
          endcase
          bus_rdy  = 1'b1;
          bus_sz8  = (w == 8);
          bus_sz16 = (w == 16) || (mode == 4);
          cyc_cnt++;
          m = ~bus_ben_n;
          if (w == 32) mv = m;
          else if (w == 16) mv = (|m[1:0]) ? (m & 4'b0011) : (m & 4'b1100);
          else mv = m & (~m + 4'd1);
          bus_rdata = $urandom;
          for (int l = 0; l < 4; l++) begin
            if (mv[l]) begin
              int pos;
              logic [31:0] a;
              pos = (w == 32) ? l : (w == 16) ? (l % 2) : 0;
              a = {bus_addr, 2'(l)};
              if (exp_a.size() == 0) begin
                chk(1'b0, "R7 extra byte", a, 32'hFFFF_FFFF);
              end else begin
                logic [31:0] ea;
                logic [7:0]  ed;
                ea = exp_a.pop_front();
                ed = exp_d.pop_front();
                chk(a == ea, "R7 byte order", a, ea);
                if (bus_we)
                  chk(bus_wdata[8*pos +: 8] == ed, "R8 write lane", 32'(bus_wdata[8*pos +: 8]), 32'(ed));
                else
                  bus_rdata[8*pos +: 8] = mem_byte(a);
              end
            end
          end
        end
      end
      if (done_valid) begin
        logic [31:0] er;
        logic        rd;
        er = exp_res.pop_front();
        rd = exp_rd.pop_front();
        if (rd) chk(done_rdata == er, "R9 read operand", done_rdata, er);
        chk(exp_a.size() == 0, "R10 all bytes before done", 32'(exp_a.size()), 0);
        chk(!bus_cyc && req_ready, "R10 idle at done", {30'd0, bus_cyc, req_ready}, 32'd1);
        dones++;
      end
    end
  end

  task automatic access(input logic [31:0] addr, input logic [1:0] len, input logic we,
                        input logic [31:0] wd, input bit spurious);
    int n, off, d0;
    logic [31:0] bnd, res;
    n = (len == 2'b00) ? 1 : (len == 2'b01) ? 2 : 4;
    off = int'(addr[1:0]);
    bnd = (addr | 32'd3) + 32'd1;
    if (off + n > 4) begin
      for (logic [31:0] a = bnd; a < addr + 32'(n); a++) begin
        exp_a.push_back(a); exp_d.push_back(we ? wd[8*(a-addr) +: 8] : 8'h00);
      end
      for (logic [31:0] a = addr; a < bnd; a++) begin
        exp_a.push_back(a); exp_d.push_back(we ? wd[8*(a-addr) +: 8] : 8'h00);
      end
    end else begin
      for (logic [31:0] a = addr; a < addr + 32'(n); a++) begin
        exp_a.push_back(a); exp_d.push_back(we ? wd[8*(a-addr) +: 8] : 8'h00);
      end
    end
    res = '0;
    for (int k = 0; k < n; k++) res[8*k +: 8] = mem_byte(addr + 32'(k));
    exp_res.push_back(res); exp_rd.push_back(!we);
    first_seen = 1'b0; cyc_cnt = 0; d0 = dones;
    @(negedge clk);
    chk(req_ready, "R2 ready when idle", 32'(req_ready), 1);
    req_valid = 1'b1; req_addr = addr; req_len = len; req_write = we; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    if (spurious) begin
      req_valid = 1'b1; req_addr = addr + 32'h40; req_len = 2'b00;
      for (int i = 0; i < 3; i++) begin
        chk(!req_ready, "R2 busy refuses request", 32'(req_ready), 0);
        @(negedge clk);
      end
      req_valid = 1'b0;
    end
    while (dones == d0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  task automatic directed(input logic [31:0] addr, input logic [1:0] len, input int md,
                          input string req);
    int n, w, exp_cyc;
    logic [7:0] span;
    logic [3:0] em;
    logic [29:0] edw;
    n = (len == 2'b00) ? 1 : (len == 2'b01) ? 2 : 4;
    w = (md == 1) ? 32 : (md == 2) ? 16 : 8;
    span = 8'((1 << n) - 1) << addr[1:0];
    exp_cyc = count_cycles(span[7:4], w) + count_cycles(span[3:0], w);
    em  = (span[7:4] != 0) ? span[7:4] : span[3:0];
    edw = addr[31:2] + ((span[7:4] != 0) ? 30'd1 : 30'd0);
    mode = md;
    access(addr, len, 1'b0, 32'h0, 1'b0);
    chk(cyc_cnt == exp_cyc, {req, " cycle count"}, 32'(cyc_cnt), 32'(exp_cyc));
    chk(first_ben == ~em, {req, " first enables"}, 32'(first_ben), 32'(~em));
    chk(first_dw == edw, {req, " first dword"}, 32'(first_dw), 32'(edw));
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk(req_ready && !bus_cyc && !done_valid && bus_ben_n == 4'hF, "R1 in reset",
        {27'd0, req_ready, bus_cyc, done_valid, 2'b00}, 32'h10);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !bus_cyc && !done_valid && bus_ben_n == 4'hF, "R1 after reset",
        {24'd0, bus_ben_n, req_ready, bus_cyc, done_valid, 1'b0}, 32'hF8);

    directed(32'h0000_0102, 2'b00, 1, "R3 byte lane2");
    directed(32'h0000_0101, 2'b01, 1, "R3 word inside dword");
    directed(32'h0000_0103, 2'b10, 1, "R4 dword at 11");
    directed(32'h0000_0207, 2'b01, 1, "R4 word across");
    directed(32'h0000_0301, 2'b10, 1, "R4 dword at 01");
    directed(32'h0000_0400, 2'b10, 2, "R5 aligned dword 16b");
    directed(32'h0000_0403, 2'b10, 2, "R5 three-byte piece 16b");
    directed(32'h0000_0502, 2'b11, 2, "R5 len11 at 10 16b");
    directed(32'h0000_0601, 2'b10, 3, "R6 dword at 01 8b");
    directed(32'h0000_0700, 2'b10, 4, "R6 sz8 over sz16");

    mode = 3;
    access(32'h0000_0800, 2'b10, 1'b1, 32'hA1B2_C3D4, 1'b1);   // R2 spurious request ignored
    mode = 2;
    access(32'h0000_0903, 2'b10, 1'b1, 32'h1122_3344, 1'b0);   // R8 steering at 16 bits

    for (int i = 0; i < 120; i++) begin
      mode = 0;                                                // R7 width mix per cycle
      access($urandom & 32'h0000_FFFF, 2'($urandom), 1'($urandom), $urandom, 1'b0);
    end

    finish_run();
  end
endmodule